// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register File

This block holds the output, direction and drive-enable state for a set of GPIO banks, each up to 32 pins wide, and puts that state on a simple memory-mapped bus. The bus is a write strobe, a byte address, write data and read data. Reads are combinational from the address. Each bank width is a parameter. The default build has four banks of 32, 22, 32 and 32 pins.

Software changes output levels through two write-only half-word ports per bank, one for the low pins and one for the high pins. The upper half of each write is a per-bit mask, so any subset of pins can be set or cleared in one bus write, with no read-modify-write.

Input levels go through a two-flop synchronizer before software reads them.

The address decoder sorts every access into one of six regions:
- RG_NONE: unmapped.
- RG_MD_LO: low mask/data port.
- RG_MD_HI: high mask/data port.
- RG_PINS: pin level readback.
- RG_DIR: direction register.
- RG_OEN: drive-enable register.

A write acts on the region selected in that cycle. A read returns the value belonging to that region.

Top module: `gpio_mdr_regs`

## Requirements
- R1: Reset clears every output latch, direction bit and drive-enable bit. After reset `pin_out` and `pin_oe` are all zero, and the direction registers read 0.
- R2: A write to byte address 8*N (bank N low port) updates output pin i (0..15) of bank N to data bit i wherever mask bit 16+i is 0.
- R3: In a mask/data write, each output pin whose mask bit is 1 keeps its previous value.
- R4: A write to byte address 8*N+4 (bank N high port) applies the same masked rule to pins 16..31, with mask bits 31:16 and data bits 15:0.
- R5: A read at byte address 0x60+4*N returns the levels of bank N's `pin_in` bits. A change on `pin_in` first appears in the read data after the second rising clock edge.
- R6: The direction register of bank N sits at byte address 0x204+0x40*N, reads back what was written, and 1 marks a pin as an output.
- R7: The drive-enable register of bank N sits at byte address 0x208+0x40*N and reads back what was written. A pin's `pin_oe` bit is 1 only when both its direction bit and its drive-enable bit are 1.
- R8: Bits at or above a bank's pin count read as 0 in every register, ignore writes, and never drive `pin_out` or `pin_oe`.
- R9: Reads of the mask/data ports, of unmapped addresses, and of any address whose two low bits are non-zero return 0. Writes to those addresses change nothing.
- R10: Register writes take effect at the rising edge on which `bus_we` is sampled high. Bank N pin b appears at flat index 32*N+b of `pin_out`, `pin_oe` and `pin_in`. With `bus_we` low, `pin_out` and `pin_oe` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NUM_BANKS*32 | Pin input levels, 32 bits per bank |
| pin_out | output | NUM_BANKS*32 | Output latch values |
| pin_oe | output | NUM_BANKS*32 | Per-pin drive enable |

## Verification
Two things can happen in the same clock: a register write that changes a pin's direction, and a level change on that pin's input arriving at the synchronizer. The bench provokes this by changing `pin_in` in the very cycle it writes the direction register of the same bank. It then reads both the direction register and the pin level register. Each must show its own new value: the direction at once, and the pin level only after the second edge. Neither may leak into or delay the other.

// File: rtl/gpio_mdr_pkg.sv
package gpio_mdr_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_MD_LO,
        RG_MD_HI,
        RG_PINS,
        RG_DIR,
        RG_OEN
    } rgn_e;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned HALF_W    = 16;
    localparam logic [31:0] PINS_BASE = 32'h060;
    localparam logic [31:0] CTRL_BASE = 32'h200;

    // Bit mask of the implemented pins in a bank of the given width.
    function automatic logic [31:0] bank_mask(input int unsigned pins);
        if (pins >= 32) return '1;
        return (32'd1 << pins) - 32'd1;
    endfunction

endpackage

// File: rtl/gpio_mdr_decode.sv
module gpio_mdr_decode
    import gpio_mdr_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned BANK_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [BANK_W-1:0] bank
);
    localparam logic [31:0] MD_END   = 32'(8 * NUM_BANKS);
    localparam logic [31:0] PINS_END = PINS_BASE + 32'(4 * NUM_BANKS);
    localparam logic [31:0] CTRL_END = CTRL_BASE + 32'(64 * NUM_BANKS);

    logic [31:0] a;
    logic [31:0] off;

    always_comb begin
        a    = 32'(addr);
        off  = a - CTRL_BASE;
        rgn  = RG_NONE;
        bank = '0;
        if (addr[1:0] != 2'b00) begin
            rgn = RG_NONE;
        end else if (a < MD_END) begin
            bank = BANK_W'(a >> 3);
            rgn  = addr[2] ? RG_MD_HI : RG_MD_LO;
        end else if (a >= PINS_BASE && a < PINS_END) begin
            bank = BANK_W'((a - PINS_BASE) >> 2);
            rgn  = RG_PINS;
        end else if (a >= CTRL_BASE && a < CTRL_END) begin
            bank = BANK_W'(off >> 6);
            if (off[5:0] == 6'h04) rgn = RG_DIR;
            else if (off[5:0] == 6'h08) rgn = RG_OEN;
        end
    end
endmodule

// File: rtl/gpio_mdr_sync.sv
module gpio_mdr_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] ff1, ff2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff1 <= '0;
            ff2 <= '0;
        end else begin
            ff1 <= d_in;
            ff2 <= ff1;
        end
    end

    assign q_out = ff2;

    // R5
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ff2 == $past(ff1));
endmodule

// File: rtl/gpio_mdr_bank.sv
module gpio_mdr_bank
    import gpio_mdr_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we_lo,
    input  logic        we_hi,
    input  logic        we_dir,
    input  logic        we_oen,
    input  logic [31:0] wdata,
    output logic [31:0] out_q,
    output logic [31:0] dir_q,
    output logic [31:0] oen_q
);
    localparam logic [31:0] VALID = bank_mask(PINS);

    logic [15:0] m, d;
    assign m = wdata[31:16];
    assign d = wdata[15:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
            oen_q <= '0;
        end else begin
            if (we_lo)
                out_q[15:0]  <= ((out_q[15:0] & m) | (d & ~m)) & VALID[15:0];
            if (we_hi)
                out_q[31:16] <= ((out_q[31:16] & m) | (d & ~m)) & VALID[31:16];
            if (we_dir) dir_q <= wdata & VALID;
            if (we_oen) oen_q <= wdata & VALID;
        end
    end

    // R3
    keep_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |=> ((out_q[15:0] & $past(wdata[31:16])) ==
                   ($past(out_q[15:0]) & $past(wdata[31:16]))));

    // R2
    take_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |=> ((out_q[15:0] & ~$past(wdata[31:16])) ==
                   ($past(wdata[15:0]) & ~$past(wdata[31:16]) & VALID[15:0])));

    // R4
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> ((out_q[31:16] & $past(wdata[31:16])) ==
                   ($past(out_q[31:16]) & $past(wdata[31:16]))));

    // R8
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q | dir_q | oen_q) & ~VALID) == 32'd0);
endmodule

// File: rtl/gpio_mdr_regs.sv
module gpio_mdr_regs
    import gpio_mdr_pkg::*;
#(
    parameter int unsigned NUM_BANKS            = 4,
    parameter int unsigned BANK_PINS[NUM_BANKS] = '{32, 22, 32, 32},
    parameter int unsigned ADDR_W               = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*32-1:0]   pin_in,
    output logic [NUM_BANKS*32-1:0]   pin_out,
    output logic [NUM_BANKS*32-1:0]   pin_oe
);
    localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned PIN_W  = NUM_BANKS * WORD_W;

    rgn_e              rgn;
    logic [BANK_W-1:0] bank;
    logic [PIN_W-1:0]  pins_sync;
    logic [31:0]       pins_rd [NUM_BANKS];
    logic [31:0]       dir_rd  [NUM_BANKS];
    logic [31:0]       oen_rd  [NUM_BANKS];

    gpio_mdr_decode #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_dec (
        .addr(bus_addr), .rgn(rgn), .bank(bank)
    );

    gpio_mdr_sync #(.W(PIN_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pins_sync)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic        hit;
        logic [31:0] out_w;
        assign hit = bus_we && (bank == BANK_W'(g));

        gpio_mdr_bank #(.PINS(BANK_PINS[g])) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (hit && rgn == RG_MD_LO),
            .we_hi (hit && rgn == RG_MD_HI),
            .we_dir(hit && rgn == RG_DIR),
            .we_oen(hit && rgn == RG_OEN),
            .wdata (bus_wdata),
            .out_q (out_w),
            .dir_q (dir_rd[g]),
            .oen_q (oen_rd[g])
        );

        assign pins_rd[g]          = pins_sync[g*32 +: 32] & bank_mask(BANK_PINS[g]);
        assign pin_out[g*32 +: 32] = out_w;
        assign pin_oe[g*32 +: 32]  = dir_rd[g] & oen_rd[g];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (rgn)
            RG_PINS: bus_rdata = pins_rd[bank];
            RG_DIR:  bus_rdata = dir_rd[bank];
            RG_OEN:  bus_rdata = oen_rd[bank];
            RG_NONE, RG_MD_LO, RG_MD_HI: bus_rdata = '0;
            default: bus_rdata = '0;
        endcase
    end

    // R9
    ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RG_NONE || rgn == RG_MD_LO || rgn == RG_MD_HI) |-> bus_rdata == 32'd0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/sim_gpio_mdr_regs.sv
module sim_gpio_mdr_regs;
    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [9:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB*32-1:0] pin_in = '0;
    logic [NB*32-1:0] pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [9:0]  a;
        logic [31:0] e;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    gpio_mdr_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Monitor: pops one expected read per cycle and compares at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (bus_rdata !== it.e) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        @(negedge clk);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        rd(10'h204, 32'h0, "R1 dir0");

        // R2 low port, full update
        wr(10'h000, 32'h0000_A5A5);
        chk("R2 low", {96'd0, pin_out[31:0]}, {96'd0, 32'h0000_A5A5});
        // R3 masked byte kept
        wr(10'h000, 32'hFF00_0F0F);
        chk("R3 keep", {96'd0, pin_out[31:0]}, {96'd0, 32'h0000_A50F});
        // R4 high port
        wr(10'h004, 32'h0000_1234);
        chk("R4 high", {96'd0, pin_out[31:0]}, {96'd0, 32'h1234_A50F});
        // R8 bank 1 has 22 pins
        wr(10'h00C, 32'h0000_FFFF);
        chk("R8 out b1", {96'd0, pin_out[63:32]}, {96'd0, 32'h003F_0000});
        // R10 flat index of bank 2
        wr(10'h010, 32'h0000_00FF);
        chk("R10 flat b2", pin_out, {32'h0, 32'h0000_00FF, 32'h003F_0000, 32'h1234_A50F});

        // R6 / R8 direction
        wr(10'h244, 32'hFFFF_FFFF);
        rd(10'h244, 32'h003F_FFFF, "R8 dir1");
        wr(10'h204, 32'h0000_00F0);
        rd(10'h204, 32'h0000_00F0, "R6 dir0");
        chk("R7 no oen", {96'd0, pin_oe[31:0]}, '0);
        // R7 drive enable
        wr(10'h208, 32'h0000_0FF0);
        rd(10'h208, 32'h0000_0FF0, "R7 oen0");
        chk("R7 oe", {96'd0, pin_oe[31:0]}, {96'd0, 32'h0000_00F0});

        // R9 zero reads and dead writes
        rd(10'h000, 32'h0, "R9 md lo");
        rd(10'h00C, 32'h0, "R9 md hi");
        rd(10'h100, 32'h0, "R9 unmapped");
        rd(10'h206, 32'h0, "R9 unaligned");
        wr(10'h100, 32'hFFFF_0000);
        wr(10'h205, 32'hFFFF_FFFF);
        rd(10'h204, 32'h0000_00F0, "R9 dir untouched");
        chk("R9 out held", pin_out, {32'h0, 32'h0000_00FF, 32'h003F_0000, 32'h1234_A50F});

        // R5 two-flop latency
        pin_in = {32'hDEAD_BEEF, 32'h0, 32'hFFFF_FFFF, 32'h0};
        rd(10'h06C, 32'h0, "R5 before");
        rd(10'h06C, 32'hDEAD_BEEF, "R5 after");
        rd(10'h064, 32'h003F_FFFF, "R8 pins b1");

        // Same cycle: direction write and pin change in bank 3
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = 10'h2C4; bus_wdata = 32'h1;
        pin_in[127:96] = 32'h0;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(10'h2C4, 32'h1, "R6 same-cycle dir");
        rd(10'h06C, 32'h0, "R5 same-cycle pins");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule